// File: doc/BRIEF.md
# Subframe CRC Appender

This block takes a bit-serial frame, one bit per cycle with start, end and valid markers, and cuts it into a fixed number of equal subframes. For each subframe it computes a CRC remainder and places those check bits in the output stream directly after that subframe's last data bit. A receiver can therefore check each piece of the frame on its own, before the rest of the frame has arrived. The output uses the same three markers as the input. They are re-timed so that the start marker sits on the first output bit and the end marker sits on the last check bit of the lengthened frame.

The frame length, subframe count, generator polynomial and seed are elaboration-time parameters. The defaults are a 10-bit frame, two 5-bit subframes, generator z^3 + z^2 + 1 and an all-zero seed. With these defaults each output frame is 16 beats long: five data bits, three check bits, five data bits, three check bits.

While check bits are being sent, the block drops its ready output, so no input is taken in those cycles. Outside those cycles ready stays high. Input cycles with valid low do not change any state.

Top module: `subframe_crc_appender`

## Requirements
- R1: After reset, out_valid, out_start and out_end are low and in_ready is high.
- R2: Each accepted data bit of an open frame appears unchanged on out_data with out_valid high, one cycle after the clock edge that accepted it, and in arrival order. out_start is high only on the output beat of an input bit that carried in_start.
- R3: The check bits of a subframe are the remainder of (subframe bits · z^3) modulo z^3 + z^2 + 1 (binary 1101), with the first-received bit taken as the highest power. The remainder register is reseeded with zero at the start of every subframe. The three check bits follow the subframe's last data bit immediately, most significant first.
- R4: A full default frame produces exactly 16 output beats in the order 5 data, 3 check, 5 data, 3 check. out_end is high only on the 16th beat, which is the last check bit.
- R5: After the edge that accepts a subframe's last bit, in_ready is low for exactly 3 consecutive cycles and then returns high.
- R6: A cycle with in_ready high and in_valid low produces no output beat on the following cycle and does not advance the frame position. A frame sent with idle gaps gives the same output beats as the same frame sent without gaps.
- R7: in_start on a bit in the middle of a frame abandons the current frame. No check bits are sent for the abandoned partial subframe, and no end marker is sent for it. That bit becomes the first bit of a new frame.
- R8: in_end on a bit before the nominal frame end closes the current subframe at that bit. Its check bits are computed over the bits received so far, and out_end is asserted on its last check bit.
- R9: Bits that arrive while no frame is open (after the end of a frame and without in_start) are accepted and discarded. They produce no output beat and they do not open a frame.
- R10: out_start and out_end are never high while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 1 | Serial input data bit |
| in_start | input | 1 | Marks the first bit of an input frame |
| in_end | input | 1 | Marks the last bit of an input frame |
| in_valid | input | 1 | Input bit present this cycle |
| in_ready | output | 1 | Block takes an input bit this cycle (low during check bits) |
| out_data | output | 1 | Serial output bit, data or check |
| out_start | output | 1 | Marks the first output beat of a frame |
| out_end | output | 1 | Marks the last check bit of a frame |
| out_valid | output | 1 | Output beat present this cycle |

## Verification
Some behaviours are checked by the assertions on every cycle. Markers never appear without out_valid. out_start is only ever produced from an accepted input start. out_end always falls on a beat sent while input was stalled. An idle input cycle gives an empty output cycle. A stall never lasts longer than the check width. The actual check-bit values, the beat order of full and shortened frames, and the effect of a mid-frame start or of bits outside any frame depend on whole bit sequences. Only the bench scenarios show these, by comparing the captured beats with remainders found by long division in the bench.

// File: rtl/crcapp_pkg.sv
`timescale 1ns/1ps
package crcapp_pkg;

    // Which kind of beat the sequencer is producing
    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_CHECK = 1'b1
    } phase_e;

    // Per-cycle control from the sequencer to the datapath
    typedef struct packed {
        logic take;       // a data bit of an open frame is consumed
        logic sub_first;  // that bit is the first of its subframe
        logic sop;        // that bit opens a frame
        logic chk;        // a check bit is emitted this cycle
        logic eop;        // the check bit closes the frame
    } ctl_t;

    // One registered output beat
    typedef struct packed {
        logic valid;
        logic dat;
        logic sop;
        logic eop;
    } beat_t;

    // Counter width that stays legal for a count of one
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/crcapp_seq.sv
`timescale 1ns/1ps
module crcapp_seq
    import crcapp_pkg::*;
#(
    parameter int unsigned SUB_BITS  = 5,
    parameter int unsigned SUB_COUNT = 2,
    parameter int unsigned CRC_W     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_end,
    output logic in_ready,
    output ctl_t ctl
);
    localparam int unsigned BW = idx_w(SUB_BITS);
    localparam int unsigned SW = idx_w(SUB_COUNT);
    localparam int unsigned CW = idx_w(CRC_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(SUB_BITS - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUB_COUNT - 1);
    localparam logic [CW-1:0] CHK_LAST = CW'(CRC_W - 1);

    phase_e        phase_q;
    logic          open_q;
    logic          last_sub_q;
    logic [BW-1:0] bit_q;
    logic [SW-1:0] sub_q;
    logic [CW-1:0] chk_q;

    logic          accept;
    logic          take;
    logic [BW-1:0] pos_bit;
    logic [SW-1:0] pos_sub;
    logic          close_sub;
    logic          close_frame;

    always_comb begin
        in_ready    = (phase_q == PH_DATA);
        accept      = in_valid && in_ready;
        // a start always opens a fresh frame, even in the middle of one
        take        = accept && (in_start || open_q);
        pos_bit     = in_start ? '0 : bit_q;
        pos_sub     = in_start ? '0 : sub_q;
        close_sub   = take && ((pos_bit == BIT_LAST) || in_end);
        close_frame = close_sub && ((pos_sub == SUB_LAST) || in_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_DATA;
            open_q     <= 1'b0;
            last_sub_q <= 1'b0;
            bit_q      <= '0;
            sub_q      <= '0;
            chk_q      <= '0;
        end else if (phase_q == PH_DATA) begin
            if (take) begin
                open_q <= !close_frame;
                if (close_sub) begin
                    phase_q    <= PH_CHECK;
                    chk_q      <= '0;
                    bit_q      <= '0;
                    last_sub_q <= close_frame;
                    sub_q      <= close_frame ? '0 : pos_sub + 1'b1;
                end else begin
                    bit_q <= pos_bit + 1'b1;
                    sub_q <= pos_sub;
                end
            end
        end else begin
            chk_q <= chk_q + 1'b1;
            if (chk_q == CHK_LAST) begin
                phase_q <= PH_DATA;
            end
        end
    end

    always_comb begin
        ctl.take      = take;
        ctl.sub_first = take && (pos_bit == '0);
        ctl.sop       = take && in_start;
        ctl.chk       = (phase_q == PH_CHECK);
        ctl.eop       = (phase_q == PH_CHECK) && (chk_q == CHK_LAST) && last_sub_q;
    end

endmodule

// File: rtl/crcapp_rem.sv
`timescale 1ns/1ps
module crcapp_rem #(
    parameter int unsigned      CRC_W = 3,
    parameter logic [CRC_W-1:0] POLY  = 3'b101,
    parameter logic [CRC_W-1:0] SEED  = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic sub_first,
    input  logic din,
    input  logic shift,
    output logic msb
);
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] stepped;
    logic             fb;

    assign base = sub_first ? SEED : rem_q;
    assign fb   = din ^ base[CRC_W-1];

    // one division step: shift left, fold in the taps when feedback is set
    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (i == 0) begin : g_low
            assign stepped[i] = fb & POLY[i];
        end else begin : g_mid
            assign stepped[i] = base[i-1] ^ (fb & POLY[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= SEED;
        end else if (take) begin
            rem_q <= stepped;
        end else if (shift) begin
            rem_q <= rem_q << 1;
        end
    end

    assign msb = rem_q[CRC_W-1];

endmodule

// File: rtl/crcapp_emit.sv
`timescale 1ns/1ps
module crcapp_emit
    import crcapp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  logic  din,
    input  logic  crc_msb,
    output beat_t beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= ctl.take || ctl.chk;
            beat.dat   <= ctl.chk ? crc_msb : din;
            beat.sop   <= ctl.sop;
            beat.eop   <= ctl.eop;
        end
    end

endmodule

// File: rtl/subframe_crc_appender.sv
`timescale 1ns/1ps
module subframe_crc_appender
    import crcapp_pkg::*;
#(
    parameter int unsigned      FRAME_BITS = 10,
    parameter int unsigned      SUB_COUNT  = 2,
    parameter int unsigned      CRC_W      = 3,
    parameter logic [CRC_W-1:0] POLY       = 3'b101,
    parameter logic [CRC_W-1:0] SEED       = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_data,
    input  logic in_start,
    input  logic in_end,
    input  logic in_valid,
    output logic in_ready,
    output logic out_data,
    output logic out_start,
    output logic out_end,
    output logic out_valid
);
    localparam int unsigned SUB_BITS = FRAME_BITS / SUB_COUNT;

    ctl_t  ctl;
    beat_t beat;
    logic  crc_msb;

    crcapp_seq #(
        .SUB_BITS (SUB_BITS),
        .SUB_COUNT(SUB_COUNT),
        .CRC_W    (CRC_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_start(in_start),
        .in_end  (in_end),
        .in_ready(in_ready),
        .ctl     (ctl)
    );

    crcapp_rem #(
        .CRC_W(CRC_W),
        .POLY (POLY),
        .SEED (SEED)
    ) u_rem (
        .clk      (clk),
        .rst      (rst),
        .take     (ctl.take),
        .sub_first(ctl.sub_first),
        .din      (in_data),
        .shift    (ctl.chk),
        .msb      (crc_msb)
    );

    crcapp_emit u_emit (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .din    (in_data),
        .crc_msb(crc_msb),
        .beat   (beat)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.dat;
    assign out_start = beat.sop;
    assign out_end   = beat.eop;

endmodule

// File: rtl/crcapp_chk.sv
`timescale 1ns/1ps
module crcapp_chk #(
    parameter int unsigned CRC_W = 3
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_start,
    input logic in_ready,
    input logic out_valid,
    input logic out_start,
    input logic out_end
);
    int unsigned stall_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_run <= 0;
        end else begin
            stall_run <= in_ready ? 0 : stall_run + 1;
        end
    end

    // R10
    start_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_valid);

    // R10
    end_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |-> out_valid);

    // R2
    start_traced_chk: assert property (@(posedge clk) disable iff (rst)
        out_start |-> $past(in_start && in_valid && in_ready));

    // R4
    end_on_check_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |-> $past(!in_ready));

    // R6
    idle_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

    // R5
    stall_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        stall_run <= CRC_W);

    // R5
    stall_emits_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> out_valid);

endmodule

bind subframe_crc_appender crcapp_chk #(.CRC_W(CRC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_start(out_start),
    .out_end  (out_end)
);

// File: tb/subframe_crc_appender_bench.sv
`timescale 1ns/1ps
module subframe_crc_appender_bench;

    logic clk = 1'b0;
    logic rst;
    logic in_data, in_start, in_end, in_valid;
    logic in_ready, out_data, out_start, out_end, out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [2:0] cap [0:511];
    int         cap_n = 0;
    logic [2:0] expb [0:127];
    int         exp_n = 0;
    int         mark  = 0;

    always #2.5 clk = ~clk;

    subframe_crc_appender u_subframe_crc_appender (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_start(in_start), .in_end(in_end), .in_valid(in_valid),
        .in_ready(in_ready),
        .out_data(out_data), .out_start(out_start), .out_end(out_end), .out_valid(out_valid)
    );

    // capture every output beat as {data, start, end}
    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 512) begin
            cap[cap_n] = {out_data, out_start, out_end};
            cap_n      = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // remainder of msg * z^3 modulo 1101, msg[n-1] is the first bit
    function automatic logic [2:0] ldiv(input logic [15:0] m, input int n);
        logic [18:0] a;
        a = {m, 3'b000};
        for (int i = n + 2; i >= 3; i--) begin
            if (a[i]) begin
                a[i]   = ~a[i];
                a[i-1] = ~a[i-1];
                a[i-3] = ~a[i-3];
            end
        end
        return a[2:0];
    endfunction

    task automatic begin_case();
        mark  = cap_n;
        exp_n = 0;
    endtask

    task automatic push_exp(input logic d, input logic s, input logic e);
        expb[exp_n] = {d, s, e};
        exp_n++;
    endtask

    // expected beats for one subframe of n bits, optionally with its check bits
    task automatic exp_sub(input logic [15:0] m, input int n, input bit sop, input bit eop, input bit with_crc);
        logic [2:0] r;
        r = ldiv(m, n);
        for (int i = n - 1; i >= 0; i--) push_exp(m[i], sop && (i == n - 1), 1'b0);
        if (with_crc) begin
            for (int k = 2; k >= 0; k--) push_exp(r[k], 1'b0, eop && (k == 0));
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic d, input logic s, input logic e);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d; in_start = s; in_end = e;
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    endtask

    task automatic send(input logic [15:0] m, input int n, input bit sop, input bit eop, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            put(m[i], sop && (i == n - 1), eop && (i == 0));
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic compare(input string req);
        chk(cap_n - mark == exp_n, {req, " beat count"}, cap_n - mark, exp_n);
        for (int i = 0; i < exp_n && i < cap_n - mark; i++) begin
            chk(cap[mark + i] == expb[i], {req, " beat"}, int'(cap[mark + i]), int'(expb[i]));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = 1'b0; in_start = 1'b0; in_end = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!out_valid && !out_start && !out_end, "R1 outputs idle", int'({out_valid, out_start, out_end}), 0);
        chk(in_ready, "R1 ready high", int'(in_ready), 1);
    endtask

    // R2 R3 R4: full frames, gapless
    task automatic t_frame(input logic [9:0] f, input string tag);
        begin_case();
        exp_sub({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 1'b1);
        exp_sub({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 1'b1);
        send({6'b0, f}, 10, 1'b1, 1'b1, 0);
        idle(6);
        compare({"R2 R3 R4 ", tag});
    endtask

    // R5: stall length after each subframe
    task automatic t_stall();
        int lows;
        logic [9:0] f = 10'b1101001011;
        begin_case();
        exp_sub({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 1'b1);
        exp_sub({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 1'b1);
        send({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 0);
        lows = 0;
        while (!in_ready && lows < 10) begin lows++; @(negedge clk); end
        chk(lows == 3, "R5 stall cycles", lows, 3);
        send({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 0);
        lows = 0;
        while (!in_ready && lows < 10) begin lows++; @(negedge clk); end
        chk(lows == 3, "R5 stall cycles last", lows, 3);
        idle(4);
        compare("R5 frame");
    endtask

    // R6: idle gaps change nothing
    task automatic t_gaps();
        logic [9:0] f = 10'b0111010010;
        begin_case();
        exp_sub({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 1'b1);
        exp_sub({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 1'b1);
        send({6'b0, f}, 10, 1'b1, 1'b1, 2);
        idle(6);
        compare("R6 gapped");
    endtask

    // R7: start in mid frame
    task automatic t_abort();
        logic [9:0] f = 10'b1010111001;
        begin_case();
        exp_sub(16'b101, 3, 1'b1, 1'b0, 1'b0);
        exp_sub({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 1'b1);
        exp_sub({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 1'b1);
        send(16'b101, 3, 1'b1, 1'b0, 0);
        send({6'b0, f}, 10, 1'b1, 1'b1, 0);
        idle(6);
        compare("R7 abort");
    endtask

    // R8: early end in the second and in the first subframe
    task automatic t_early();
        begin_case();
        exp_sub(16'b11011, 5, 1'b1, 1'b0, 1'b1);
        exp_sub(16'b10, 2, 1'b0, 1'b1, 1'b1);
        send(16'b1101110, 7, 1'b1, 1'b1, 0);
        idle(6);
        compare("R8 end in second");
        begin_case();
        exp_sub(16'b111, 3, 1'b1, 1'b1, 1'b1);
        send(16'b111, 3, 1'b1, 1'b1, 0);
        idle(6);
        compare("R8 end in first");
    endtask

    // R9: bits outside any frame
    task automatic t_drop();
        logic [9:0] f = 10'b0010110111;
        begin_case();
        send(16'b1011, 4, 1'b0, 1'b0, 0);
        chk(in_ready, "R9 no stall", int'(in_ready), 1);
        idle(4);
        compare("R9 dropped");
        begin_case();
        exp_sub({11'b0, f[9:5]}, 5, 1'b1, 1'b0, 1'b1);
        exp_sub({11'b0, f[4:0]}, 5, 1'b0, 1'b1, 1'b1);
        send({6'b0, f}, 10, 1'b1, 1'b1, 0);
        idle(6);
        compare("R9 next frame");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_frame(10'b1011001110, "mixed");
        t_frame(10'b0000011111, "zero then ones");
        t_frame(10'b1111111111, "all ones");
        t_stall();
        t_gaps();
        t_abort();
        t_early();
        t_drop();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule